// File: doc/BRIEF.md
# Up/Down Timer with Update Requests

This block is a general-purpose timer. A prescaler divides the clock by (prescale + 1), and each prescaled tick moves a counter up or down. The counter runs between zero and a reload limit. Each time it wraps, the timer raises an update event. The update event sets a sticky flag. Behind separate enables, it also drives a level interrupt request and a one-cycle DMA request.

The control and status pins are plain. Software writes registers through a single-cycle write port and reads them through a combinational read port. There is no data stream and no back-pressure: every write is accepted in the cycle it is presented.

The prescale and reload values pass through holding registers. While the timer runs, a new value takes effect only at the next update event. While it is stopped, a new value takes effect at once. A single-shot option stops the timer at the update that ends the current period.

Register map (3-bit address):
- 0, control: bit 0 is run, bit 1 is down, bit 2 is single-shot.
- 1, request enables: bit 0 enables the interrupt, bit 1 enables the DMA request.
- 2, status: bit 0 is the update flag. Writing 1 to bit 0 clears it.
- 3, prescale.
- 4, reload.
- 5, count. This register is read-only.

Top module: `tmr_updown`

## Requirements
- R1: After reset, the control, request-enable, status, prescale, reload and count registers all read 0, and both irq and dma_req are low.
- R2: While run (control bit 0) is 1, the count changes exactly once every prescale+1 clock cycles. While run is 0, the count holds its value.
- R3: With down (control bit 1) at 0, a tick at count == reload raises an update and returns the count to 0. Otherwise the tick adds 1. The period is therefore (reload+1)*(prescale+1) cycles.
- R4: With down at 1, a tick at count == 0 raises an update and loads the count with the held reload value. Otherwise the tick subtracts 1.
- R5: While the timer runs, a write to prescale or reload takes effect only from the next update event. While it is stopped, the written value applies at once.
- R6: Every update sets status bit 0. The bit stays set until a write with data bit 0 = 1 to address 2. A write with bit 0 = 0 leaves it set, and an update in the same cycle as a clear wins.
- R7: irq is high exactly while status bit 0 and the interrupt enable (address 1, bit 0) are both 1.
- R8: When the DMA enable (address 1, bit 1) is 1, dma_req is high for the one cycle after each update. Otherwise it stays low.
- R9: With single-shot (control bit 2) at 1, the update clears run in the same clock edge. Counting then stops with the count at its wrapped value, and single-shot stays set.
- R10: A write to the count address (5) leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the clock edge |
| wr_addr | input | 3 | Register address for the write |
| wr_data | input | BUS_W | Write data |
| rd_addr | input | 3 | Register address for the combinational read |
| rd_data | output | BUS_W | Read data, zero-extended |
| irq | output | 1 | Update interrupt request (level) |
| dma_req | output | 1 | Update DMA request (one-cycle pulse) |

## Verification
The assertions watch the following on every cycle:
- the count holds between ticks;
- the count wraps to 0 after an up-counting update;
- the count reloads after a down-counting update;
- the flag rises only after an update;
- every DMA pulse follows an enabled update;
- single-shot clears run.

Some behaviour only the bench scenarios can show. These are the exact cycle of each update for several prescale, reload and direction settings, the deferred take-up of a reload written mid-period, the interrupt gating, the write-one-to-clear rule, and the ignored count write. The bench checks them by comparing DMA pulse times against a queue of predicted cycles and by reading the registers back.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_ADDR_W = 3;

  typedef enum logic [TMR_ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_REQEN  = 3'd1,
    REG_STATUS = 3'd2,
    REG_PRESC  = 3'd3,
    REG_RELOAD = 3'd4,
    REG_COUNT  = 3'd5
  } tmr_reg_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_DOWN_BIT = 1;
  localparam int CTRL_ONCE_BIT = 2;
  localparam int REQ_IRQ_BIT   = 0;
  localparam int REQ_DMA_BIT   = 1;
  localparam int STAT_UPD_BIT  = 0;

  typedef struct packed {
    logic once;
    logic down;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int BUS_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [TMR_ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]      wr_data,
  input  logic [TMR_ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]      rd_data,
  input  logic [CNT_W-1:0]      cnt_val,
  input  logic                  upd,
  output tmr_ctrl_t             ctrl,
  output logic                  irq_en,
  output logic                  dma_en,
  output logic                  flag,
  output logic [PSC_W-1:0]      psc_pre,
  output logic [CNT_W-1:0]      arr_pre
);
  logic clr_hit;
  assign clr_hit = wr_en && (tmr_reg_e'(wr_addr) == REG_STATUS) && wr_data[STAT_UPD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      irq_en  <= 1'b0;
      dma_en  <= 1'b0;
      psc_pre <= '0;
      arr_pre <= '0;
    end else begin
      if (wr_en) begin
        case (tmr_reg_e'(wr_addr))
          REG_CTRL: begin
            ctrl.run  <= wr_data[CTRL_RUN_BIT];
            ctrl.down <= wr_data[CTRL_DOWN_BIT];
            ctrl.once <= wr_data[CTRL_ONCE_BIT];
          end
          REG_REQEN: begin
            irq_en <= wr_data[REQ_IRQ_BIT];
            dma_en <= wr_data[REQ_DMA_BIT];
          end
          REG_PRESC:  psc_pre <= wr_data[PSC_W-1:0];
          REG_RELOAD: arr_pre <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
      // single-shot: the terminating update overrides any write of run
      if (upd && ctrl.once) ctrl.run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (upd)     flag <= 1'b1;
    else if (clr_hit) flag <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (tmr_reg_e'(rd_addr))
      REG_CTRL: begin
        rd_data[CTRL_RUN_BIT]  = ctrl.run;
        rd_data[CTRL_DOWN_BIT] = ctrl.down;
        rd_data[CTRL_ONCE_BIT] = ctrl.once;
      end
      REG_REQEN: begin
        rd_data[REQ_IRQ_BIT] = irq_en;
        rd_data[REQ_DMA_BIT] = dma_en;
      end
      REG_STATUS: rd_data[STAT_UPD_BIT] = flag;
      REG_PRESC:  rd_data[PSC_W-1:0]    = psc_pre;
      REG_RELOAD: rd_data[CNT_W-1:0]    = arr_pre;
      REG_COUNT:  rd_data[CNT_W-1:0]    = cnt_val;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             upd,
  input  logic [PSC_W-1:0] psc_pre,
  output logic             tick
);
  logic [PSC_W-1:0] psc_act;
  logic [PSC_W-1:0] psc_cnt;

  assign tick = run && (psc_cnt == psc_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act <= '0;
      psc_cnt <= '0;
    end else begin
      if (!run || upd) psc_act <= psc_pre;
      if (!run || tick) psc_cnt <= '0;
      else              psc_cnt <= psc_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             down,
  input  logic [CNT_W-1:0] arr_pre,
  output logic [CNT_W-1:0] cnt,
  output logic             upd
);
  logic [CNT_W-1:0] arr_act;
  logic             at_end;

  assign at_end = down ? (cnt == '0) : (cnt == arr_act);
  assign upd    = tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_act <= '0;
      cnt     <= '0;
    end else begin
      if (!run || upd) arr_act <= arr_pre;
      if (tick) begin
        if (upd)       cnt <= down ? arr_pre : '0;
        else if (down) cnt <= cnt - 1'b1;
        else           cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_req.sv
module tmr_req (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic flag,
  input  logic irq_en,
  input  logic dma_en,
  output logic irq,
  output logic dma_req
);
  assign irq = flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_req <= 1'b0;
    else        dma_req <= upd && dma_en;
  end
endmodule

// File: rtl/tmr_updown.sv
module tmr_updown
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int BUS_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [TMR_ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]      wr_data,
  input  logic [TMR_ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]      rd_data,
  output logic                  irq,
  output logic                  dma_req
);
  tmr_ctrl_t        ctrl;
  logic             run_q, down_q, once_q;
  logic             irq_en, dma_en, flag;
  logic [PSC_W-1:0] psc_pre;
  logic [CNT_W-1:0] arr_pre;
  logic [CNT_W-1:0] cnt;
  logic             tick, upd;

  assign run_q  = ctrl.run;
  assign down_q = ctrl.down;
  assign once_q = ctrl.once;

  tmr_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_val(cnt), .upd(upd), .ctrl(ctrl),
    .irq_en(irq_en), .dma_en(dma_en), .flag(flag), .psc_pre(psc_pre), .arr_pre(arr_pre)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .upd(upd), .psc_pre(psc_pre), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick), .down(down_q),
    .arr_pre(arr_pre), .cnt(cnt), .upd(upd)
  );

  tmr_req u_req (
    .clk(clk), .rst_n(rst_n), .upd(upd), .flag(flag), .irq_en(irq_en),
    .dma_en(dma_en), .irq(irq), .dma_req(dma_req)
  );
endmodule

// File: rtl/tmr_updown_chk.sv
module tmr_updown_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             upd,
  input logic             down,
  input logic             once,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] arr_pre,
  input logic             flag,
  input logic             dma_en,
  input logic             dma_req
);
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_up_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !down) |=> (cnt == '0));

  assert_down_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && down) |=> (cnt == $past(arr_pre)));

  assert_flag_after_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(upd));

  assert_dma_follows_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(upd && dma_en));

  assert_once_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && once) |=> !run);
endmodule

bind tmr_updown tmr_updown_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .upd(upd), .down(down_q), .once(once_q),
  .run(run_q), .cnt(cnt), .arr_pre(arr_pre), .flag(flag), .dma_en(dma_en),
  .dma_req(dma_req)
);

// File: tb/tmr_updown_bench.sv
module tmr_updown_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  rd_addr;
  logic [15:0] rd_data;
  logic        irq;
  logic        dma_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];

  tmr_updown u_tmr_updown (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .dma_req(dma_req)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: each DMA pulse is compared with the next predicted cycle
  always @(negedge clk) begin
    if (rst_n && dma_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected request pulse actual cycle %0d expected none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R3/R4/R5 request pulse actual cycle %0d expected %0d", cyc, e);
        end
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, output int at);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    at = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    rd_addr = a;
    #1;
    d = int'(rd_data);
  endtask

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e0, t, v, c1;
    do_reset();

    // R1 reset values
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 irq reset", int'(irq), 0);
    chk("R1 dma reset", int'(dma_req), 0);

    // R3 up counting, prescale 0, reload 4
    wr(3'd3, 16'd0, t); wr(3'd4, 16'd4, t); wr(3'd1, 16'd2, t);
    wr(3'd0, 16'd1, e0);
    exp_q.push_back(e0 + 5); exp_q.push_back(e0 + 10); exp_q.push_back(e0 + 15);
    wait_to(e0 + 2); rd(3'd5, v); chk("R3 count mid period", v, 2);
    wait_to(e0 + 16);
    chk("R8 all pulses seen up", exp_q.size(), 0);
    rd(3'd2, v); chk("R6 flag after updates", v, 1);
    chk("R7 irq masked", int'(irq), 0);
    wr(3'd0, 16'd0, t);
    rd(3'd5, c1); wait_to(t + 5); rd(3'd5, v);
    chk("R2 count holds when stopped", v, c1);

    // R2 prescale 2, reload 3 (R5: written while stopped, applies at once)
    do_reset();
    wr(3'd3, 16'd2, t); wr(3'd4, 16'd3, t); wr(3'd1, 16'd2, t);
    wr(3'd0, 16'd1, e0);
    exp_q.push_back(e0 + 12); exp_q.push_back(e0 + 24);
    wait_to(e0 + 3); rd(3'd5, v); chk("R2 first tick", v, 1);
    wait_to(e0 + 5); rd(3'd5, v); chk("R2 no tick between", v, 1);
    wait_to(e0 + 6); rd(3'd5, v); chk("R2 second tick", v, 2);
    wait_to(e0 + 26);
    chk("R2 all pulses seen", exp_q.size(), 0);

    // R4 down counting, prescale 1, reload 2
    do_reset();
    wr(3'd3, 16'd1, t); wr(3'd4, 16'd2, t); wr(3'd1, 16'd2, t);
    wr(3'd0, 16'd3, e0);
    exp_q.push_back(e0 + 2); exp_q.push_back(e0 + 8); exp_q.push_back(e0 + 14);
    wait_to(e0 + 2); rd(3'd5, v); chk("R4 reload after update", v, 2);
    wait_to(e0 + 4); rd(3'd5, v); chk("R4 decrement", v, 1);
    wait_to(e0 + 15);
    chk("R4 all pulses seen", exp_q.size(), 0);

    // R5 reload written while running applies from next update
    do_reset();
    wr(3'd3, 16'd0, t); wr(3'd4, 16'd4, t); wr(3'd1, 16'd2, t);
    wr(3'd0, 16'd1, e0);
    exp_q.push_back(e0 + 5); exp_q.push_back(e0 + 8); exp_q.push_back(e0 + 11);
    wr(3'd4, 16'd2, t);
    wait_to(e0 + 12);
    chk("R5 deferred reload pulses seen", exp_q.size(), 0);

    // R6 R7 R10 flag, interrupt gating, count write ignored, no DMA
    do_reset();
    wr(3'd4, 16'd2, t); wr(3'd1, 16'd1, t);
    wr(3'd0, 16'd1, e0);
    wait_to(e0 + 2); chk("R7 irq low before update", int'(irq), 0);
    wait_to(e0 + 3); chk("R7 irq high after update", int'(irq), 1);
    rd(3'd2, v); chk("R6 flag set", v, 1);
    wr(3'd0, 16'd0, t);
    rd(3'd5, c1); wr(3'd5, 16'h55, t); rd(3'd5, v);
    chk("R10 count write ignored", v, c1);
    wr(3'd2, 16'd0, t); rd(3'd2, v); chk("R6 write zero keeps flag", v, 1);
    wr(3'd2, 16'd1, t); rd(3'd2, v); chk("R6 write one clears flag", v, 0);
    chk("R7 irq low after clear", int'(irq), 0);

    // R9 single-shot
    do_reset();
    wr(3'd4, 16'd3, t); wr(3'd1, 16'd2, t);
    wr(3'd0, 16'd5, e0);
    exp_q.push_back(e0 + 4);
    wait_to(e0 + 4);
    rd(3'd0, v); chk("R9 run cleared once kept", v, 4);
    rd(3'd5, v); chk("R9 count wrapped", v, 0);
    wait_to(e0 + 12);
    chk("R9 single pulse only", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule